// File: doc/BRIEF.md
# Cascaded Timer Unit with Shared Prescaler

This block holds four 8-bit down-counting timers and one prescaler for a small microcontroller. The prescaler divides the system clock by 4 or by 16. Each timer counts one source, chosen by a 2-bit field in its control register. The sources are the prescaler tick, the underflow of the timer before it, a synchronized external counter pin, or a watchdog underflow pulse. When a timer passes zero it reloads from its reload register and raises a one-cycle underflow pulse. That pulse can drive the next timer in the chain, so timers can be joined into longer periods.

Software writes five 4-bit control registers over a simple write/read bus, and writes reload values through a separate port. Two counter pins give a divide-by-two square wave, toggled by underflows of a chosen timer, and each pin has an output-enable bit. All count sources become single-cycle enables in the system clock domain. Every stage of the cascade adds one cycle of latency.

Top module: `cascade_timer_unit`

## Requirements
- R1: Control register 0 (address 0) holds the prescaler bits. Bit 3 enables the prescaler and bit 2 selects the ratio: 0 gives a tick every 4 clocks and 1 gives a tick every 16 clocks. Timer 1 always counts prescaler ticks. It is enabled by bit 1 of this register and has no ticks while bit 3 is 0.
- R2: While the prescaler is disabled its phase is held at zero. After it is re-enabled, with ratio 4, a timer 1 holding count 0 and reload 0 shows its underflow on the 4th clock after the enabling write.
- R3: Each timer is an 8-bit down counter and resets to 0xFF with a reload of 0xFF. A reload write sets both the reload register and the count. With reload N, a timer underflows once every N+1 counted events. On underflow it reloads and pulses its `tmr_uf` bit for one clock, one cycle after the event.
- R4: Clearing a timer's enable bit (bit 3 of control registers 1 to 3 for timers 2 to 4) freezes that timer's count. Setting the bit again resumes counting from the held value.
- R5: Timer 2's source field, bits 1:0 of register 1, selects 00 = timer 1 underflow, 01 = prescaler tick, 10 = external pin 0 event, 11 = watchdog underflow pulse.
- R6: Timer 3's source field, bits 1:0 of register 2, selects 00 = timer 2 underflow and 01 = prescaler tick. Codes 10 and 11 produce no counts.
- R7: Timer 4's source field, bits 1:0 of register 3, selects 00 = timer 3 underflow, 01 = prescaler tick, 10 = external pin 1 event. Code 11 produces no counts.
- R8: Start synchronization is set by bit 0 of register 0 for timer 1 and by bit 2 of register 2 for timer 3. When it is set, the first source event after the timer is enabled only arms the timer. Counting starts with the next event.
- R9: Each external pin passes through two synchronizing flops. Each rising edge gives exactly one count event, however long the pin stays high.
- R10: Register 4 (address 4) controls the counter pins. Bit 0 enables pin 0's output. Bit 1 makes pin 0 toggle on timer 2 underflows when 1, or on timer 1 underflows when 0. Bit 2 enables pin 1's output. Bit 3 makes pin 1 toggle on timer 4 underflows when 1, or on timer 3 underflows when 0. Both toggles reset to 0.
- R11: All five control registers reset to 0000 and read back what was written, including the function-free bit 2 of registers 1 and 3. Addresses 5 to 7 read 0000 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_addr | input | 3 | Control register address (0 to 4) |
| ctl_wdata | input | 4 | Control register write data |
| ctl_rdata | output | 4 | Read data of the addressed register (combinational) |
| rld_we | input | 1 | Reload write strobe |
| rld_idx | input | 2 | Timer index of the reload write (0 = timer 1) |
| rld_value | input | W | Reload value, also loaded into the count |
| ext_in0 | input | 1 | External counter pin 0 input (asynchronous) |
| ext_in1 | input | 1 | External counter pin 1 input (asynchronous) |
| wdt_uf | input | 1 | Watchdog underflow pulse, one clock wide |
| tmr_uf | output | 4 | Underflow pulses, bit i for timer i+1 |
| tmr_count | output | 4*W | Current counts, timer i+1 at bits i*W+W-1 : i*W |
| pin_out0 | output | 1 | Counter pin 0 toggle output |
| pin_out1 | output | 1 | Counter pin 1 toggle output |
| pin_oe0 | output | 1 | Counter pin 0 output enable |
| pin_oe1 | output | 1 | Counter pin 1 output enable |

## Verification
The arming event of start synchronization is the hardest case to isolate. With the prescaler as source, the arming tick falls at a phase that cannot be seen from outside. The stimulus stops the prescaler and feeds timer 3 from timer 2. Timer 2 runs with reload 0 on external pin 0, so each hand-driven rising edge gives exactly one timer 3 event, and the count left after four edges shows whether one edge was spent on arming. The long cascade periods are reached with small reload values. The bench counts underflows over a window that is an exact multiple of the chain's period.

// File: rtl/cascade_timer_unit.sv
module cascade_timer_unit #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_we,
  input  logic [2:0]     ctl_addr,
  input  logic [3:0]     ctl_wdata,
  output logic [3:0]     ctl_rdata,
  input  logic           rld_we,
  input  logic [1:0]     rld_idx,
  input  logic [W-1:0]   rld_value,
  input  logic           ext_in0,
  input  logic           ext_in1,
  input  logic           wdt_uf,
  output logic [3:0]     tmr_uf,
  output logic [4*W-1:0] tmr_count,
  output logic           pin_out0,
  output logic           pin_out1,
  output logic           pin_oe0,
  output logic           pin_oe1
);
  logic [3:0] c_ps, c_t2, c_t3, c_t4, c_pin;
  logic [3:0] ps_cnt;
  logic [W-1:0] cnt [4];
  logic [W-1:0] rld [4];
  logic [3:0] arm, tick, en, syn, go;
  logic [2:0] sy0, sy1;
  logic tg0, tg1;

  wire pre_tick = c_ps[3] & (c_ps[2] ? &ps_cnt : &ps_cnt[1:0]);
  wire ev0 = sy0[1] & ~sy0[2];
  wire ev1 = sy1[1] & ~sy1[2];

  always_comb begin
    tick[0] = pre_tick;
    case (c_t2[1:0])
      2'b00:   tick[1] = tmr_uf[0];
      2'b01:   tick[1] = pre_tick;
      2'b10:   tick[1] = ev0;
      default: tick[1] = wdt_uf;
    endcase
    case (c_t3[1:0])
      2'b00:   tick[2] = tmr_uf[1];
      2'b01:   tick[2] = pre_tick;
      default: tick[2] = 1'b0;
    endcase
    case (c_t4[1:0])
      2'b00:   tick[3] = tmr_uf[2];
      2'b01:   tick[3] = pre_tick;
      2'b10:   tick[3] = ev1;
      default: tick[3] = 1'b0;
    endcase
  end

  assign en  = {c_t4[3], c_t3[3], c_t2[3], c_ps[1]};
  assign syn = {1'b0, c_t3[2], 1'b0, c_ps[0]};
  assign go  = en & (arm | ~syn);

  always_comb begin
    case (ctl_addr)
      3'd0:    ctl_rdata = c_ps;
      3'd1:    ctl_rdata = c_t2;
      3'd2:    ctl_rdata = c_t3;
      3'd3:    ctl_rdata = c_t4;
      3'd4:    ctl_rdata = c_pin;
      default: ctl_rdata = 4'b0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {c_ps, c_t2, c_t3, c_t4, c_pin} <= '0;
      ps_cnt <= '0;
      sy0 <= '0;
      sy1 <= '0;
      arm <= '0;
      tg0 <= 1'b0;
      tg1 <= 1'b0;
      tmr_uf <= '0;
      for (int i = 0; i < 4; i++) begin
        cnt[i] <= '1;
        rld[i] <= '1;
      end
    end else begin
      if (ctl_we) begin
        case (ctl_addr)
          3'd0: c_ps  <= ctl_wdata;
          3'd1: c_t2  <= ctl_wdata;
          3'd2: c_t3  <= ctl_wdata;
          3'd3: c_t4  <= ctl_wdata;
          3'd4: c_pin <= ctl_wdata;
          default: ;
        endcase
      end
      ps_cnt <= c_ps[3] ? ps_cnt + 4'd1 : 4'd0;
      sy0 <= {sy0[1:0], ext_in0};
      sy1 <= {sy1[1:0], ext_in1};
      arm <= en & (arm | tick);
      tg0 <= tg0 ^ (c_pin[1] ? tmr_uf[1] : tmr_uf[0]);
      tg1 <= tg1 ^ (c_pin[3] ? tmr_uf[3] : tmr_uf[2]);
      for (int i = 0; i < 4; i++) begin
        tmr_uf[i] <= 1'b0;
        if (rld_we && rld_idx == 2'(i)) begin
          rld[i] <= rld_value;
          cnt[i] <= rld_value;
        end else if (go[i] && tick[i]) begin
          if (cnt[i] == '0) begin
            cnt[i] <= rld[i];
            tmr_uf[i] <= 1'b1;
          end else begin
            cnt[i] <= cnt[i] - 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < 4; g++) begin : g_out
    assign tmr_count[g*W +: W] = cnt[g];

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en[g] && !(rld_we && rld_idx == 2'(g))) |=> $stable(tmr_count[g*W +: W]));

    assert_uf_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_uf[g] |-> tmr_count[g*W +: W] == rld[g]);
  end

  assign pin_out0 = tg0;
  assign pin_out1 = tg1;
  assign pin_oe0  = c_pin[0];
  assign pin_oe1  = c_pin[2];

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

  assert_ps_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_ps[3]) |-> ps_cnt == 4'd0);

  assert_t3_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_t3[1] && !(rld_we && rld_idx == 2'd2)) |=> $stable(tmr_count[2*W +: W]));

  assert_pin_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out0 != $past(pin_out0)) |-> $past(c_pin[1] ? tmr_uf[1] : tmr_uf[0]));
endmodule

// File: tb/tb_cascade_timer_unit.sv
module tb_cascade_timer_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_we = 1'b0;
  logic [2:0] ctl_addr = '0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_rdata;
  logic rld_we = 1'b0;
  logic [1:0] rld_idx = '0;
  logic [7:0] rld_value = '0;
  logic ext_in0 = 1'b0, ext_in1 = 1'b0, wdt_uf = 1'b0;
  logic [3:0] tmr_uf;
  logic [31:0] tmr_count;
  logic pin_out0, pin_out1, pin_oe0, pin_oe1;

  always #2 clk = ~clk;

  cascade_timer_unit #(.W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .rld_we(rld_we),
    .rld_idx(rld_idx), .rld_value(rld_value), .ext_in0(ext_in0),
    .ext_in1(ext_in1), .wdt_uf(wdt_uf), .tmr_uf(tmr_uf),
    .tmr_count(tmr_count), .pin_out0(pin_out0), .pin_out1(pin_out1),
    .pin_oe0(pin_oe0), .pin_oe1(pin_oe1));

  int errors = 0, checks = 0, cyc = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural reference model
  logic [3:0] m_ctl [5];
  int m_ps;
  int m_cnt [4];
  int m_rld [4];
  bit m_uf [4];
  bit m_arm [4];
  bit s0 [3];
  bit s1 [3];
  bit m_tg0, m_tg1;

  task automatic model_reset();
    for (int i = 0; i < 5; i++) m_ctl[i] = 4'b0000;
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 255; m_rld[i] = 255; m_uf[i] = 0; m_arm[i] = 0;
    end
    for (int i = 0; i < 3; i++) begin s0[i] = 0; s1[i] = 0; end
    m_ps = 0; m_tg0 = 0; m_tg1 = 0;
  endtask

  task automatic model_step();
    bit pre, e0, e1;
    bit tk [4];
    bit en [4];
    bit sy [4];
    bit go;
    pre = m_ctl[0][3] && (m_ctl[0][2] ? (m_ps == 15) : (m_ps % 4 == 3));
    e0 = s0[1] && !s0[2];
    e1 = s1[1] && !s1[2];
    tk[0] = pre;
    case (m_ctl[1][1:0])
      0: tk[1] = m_uf[0];
      1: tk[1] = pre;
      2: tk[1] = e0;
      default: tk[1] = wdt_uf;
    endcase
    tk[2] = (m_ctl[2][1:0] == 0) ? m_uf[1] : (m_ctl[2][1:0] == 1) ? pre : 1'b0;
    case (m_ctl[3][1:0])
      0: tk[3] = m_uf[2];
      1: tk[3] = pre;
      2: tk[3] = e1;
      default: tk[3] = 0;
    endcase
    en[0] = m_ctl[0][1]; en[1] = m_ctl[1][3]; en[2] = m_ctl[2][3]; en[3] = m_ctl[3][3];
    sy[0] = m_ctl[0][0]; sy[1] = 0; sy[2] = m_ctl[2][2]; sy[3] = 0;
    if (m_ctl[4][1] ? m_uf[1] : m_uf[0]) m_tg0 = !m_tg0;
    if (m_ctl[4][3] ? m_uf[3] : m_uf[2]) m_tg1 = !m_tg1;
    for (int i = 0; i < 4; i++) begin
      go = en[i] && (m_arm[i] || !sy[i]);
      m_arm[i] = en[i] && (m_arm[i] || tk[i]);
      m_uf[i] = 0;
      if (rld_we && rld_idx == i) begin
        m_rld[i] = rld_value; m_cnt[i] = rld_value;
      end else if (go && tk[i]) begin
        if (m_cnt[i] == 0) begin m_cnt[i] = m_rld[i]; m_uf[i] = 1; end
        else m_cnt[i] = m_cnt[i] - 1;
      end
    end
    m_ps = m_ctl[0][3] ? (m_ps + 1) % 16 : 0;
    s0[2] = s0[1]; s0[1] = s0[0]; s0[0] = ext_in0;
    s1[2] = s1[1]; s1[1] = s1[0]; s1[0] = ext_in1;
    if (ctl_we && ctl_addr < 5) m_ctl[ctl_addr] = ctl_wdata;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  // compare against the model on every clock
  always @(negedge clk) begin
    logic [31:0] ecnt;
    logic [3:0] euf;
    if (rst_n && !done) begin
      for (int i = 0; i < 4; i++) begin
        ecnt[i*8 +: 8] = m_cnt[i][7:0];
        euf[i] = m_uf[i];
      end
      checks++;
      if (tmr_count !== ecnt || tmr_uf !== euf) begin
        errors++;
        $display("FAIL %s cycle %0d: count=%h uf=%b expected count=%h uf=%b (R3)",
                 cur_req, cyc, tmr_count, tmr_uf, ecnt, euf);
      end
      checks++;
      if (pin_out0 !== m_tg0 || pin_out1 !== m_tg1 ||
          pin_oe0 !== m_ctl[4][0] || pin_oe1 !== m_ctl[4][2]) begin
        errors++;
        $display("FAIL %s/R10 cycle %0d: pins out=%b%b oe=%b%b expected out=%b%b oe=%b%b",
                 cur_req, cyc, pin_out1, pin_out0, pin_oe1, pin_oe0,
                 m_tg1, m_tg0, m_ctl[4][2], m_ctl[4][0]);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] d);
    @(negedge clk); #1 ctl_we = 1; ctl_addr = 3'(a); ctl_wdata = d;
    @(negedge clk); #1 ctl_we = 0;
  endtask

  task automatic ld(input int i, input int v);
    @(negedge clk); #1 rld_we = 1; rld_idx = 2'(i); rld_value = 8'(v);
    @(negedge clk); #1 rld_we = 0;
  endtask

  task automatic rd(input int a, input int exp, input string req);
    @(negedge clk); #1 ctl_addr = 3'(a); #1;
    check(req, int'(ctl_rdata), exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic gap0(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tmr_uf[0] && n < 1000);
  endtask

  task automatic pulse_ext(input int pin);
    @(negedge clk); #1 if (pin == 0) ext_in0 = 1; else ext_in1 = 1;
    repeat (3) @(negedge clk);
    #1 if (pin == 0) ext_in0 = 0; else ext_in1 = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic int tcnt(input int i);
    return int'(tmr_count[i*8 +: 8]);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int n, a, b, held;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;

    // R11 reset values, read/write, spare bits
    cur_req = "R11";
    for (int i = 0; i < 5; i++) rd(i, 0, "R11 reset");
    check("R11 reset count", int'(tmr_count), -1);
    wr(1, 4'b0100); rd(1, 4, "R11 spare bit reg1");
    wr(3, 4'b0100); rd(3, 4, "R11 spare bit reg3");
    wr(5, 4'b1111); rd(5, 0, "R11 unused address");
    wr(1, 0); wr(3, 0);

    // R1 prescaler ratios
    cur_req = "R1";
    ld(0, 0);
    wr(0, 4'b1010);
    gap0(n); gap0(n); check("R1 ratio 4", n, 4);
    wr(0, 4'b1110);
    gap0(n); gap0(n); gap0(n); check("R1 ratio 16", n, 16);

    // R2 prescaler stop clears phase
    cur_req = "R2";
    wr(0, 4'b0010); idle(13);
    check("R2 no tick while stopped", int'(tmr_uf[0]), 0);
    wr(0, 4'b1010);
    gap0(n); check("R2 restart latency", n, 4);

    // R3 cascade over several reloads
    cur_req = "R3";
    ld(0, 3); ld(1, 2); ld(2, 1); ld(3, 1);
    wr(1, 4'b1000); wr(2, 4'b1000); wr(3, 4'b1000);
    idle(600);
    a = 0; b = 0;
    repeat (1920) begin
      @(negedge clk);
      a += tmr_uf[3]; b += tmr_uf[0];
    end
    check("R3 timer4 underflows in 1920 cycles", a, 10);
    check("R3 timer1 underflows in 1920 cycles", b, 120);

    // R4 stop holds count
    cur_req = "R4";
    wr(1, 4'b0000);
    held = tcnt(1);
    idle(60);
    check("R4 held count", tcnt(1), held);
    wr(1, 4'b1000); idle(100);

    // R10 toggle outputs
    cur_req = "R10";
    wr(4, 4'b0101);
    check("R10 oe0", int'(pin_oe0), 1);
    check("R10 oe1", int'(pin_oe1), 1);
    a = 0; b = 0;
    repeat (400) begin
      logic p;
      p = pin_out0;
      @(negedge clk);
      a += (pin_out0 != p); b += tmr_uf[0];
    end
    check("R10 pin0 toggles vs timer1 underflows", a, b);
    wr(4, 4'b1010);
    check("R10 oe off", int'(pin_oe0) + int'(pin_oe1), 0);
    a = 0; b = 0;
    repeat (800) begin
      logic p;
      p = pin_out1;
      @(negedge clk);
      a += (pin_out1 != p); b += tmr_uf[3];
    end
    check("R10 pin1 toggles vs timer4 underflows", a, b);

    // R5 timer 2 sources
    cur_req = "R5";
    wr(2, 0); wr(3, 0); wr(0, 4'b1000);
    wr(1, 4'b1001); idle(100);
    cur_req = "R9";
    wr(0, 0);
    wr(1, 4'b1010); ld(1, 255);
    for (int k = 0; k < 5; k++) pulse_ext(0);
    idle(6);
    check("R9 five rising edges on pin 0", tcnt(1), 250);
    cur_req = "R5";
    wr(1, 4'b1011); ld(1, 255);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1 wdt_uf = 1;
      @(negedge clk); #1 wdt_uf = 0;
      idle(2);
    end
    idle(3);
    check("R5 watchdog source", tcnt(1), 252);

    // R6 timer 3 unavailable codes
    cur_req = "R6";
    wr(0, 4'b1000);
    wr(1, 4'b1001); ld(1, 0);
    wr(2, 4'b1010);
    held = tcnt(2); idle(60);
    check("R6 code 10 no counts", tcnt(2), held);
    wr(2, 4'b1011); idle(60);
    check("R6 code 11 no counts", tcnt(2), held);
    wr(2, 4'b1001); idle(80);

    // R7 timer 4 sources
    cur_req = "R7";
    wr(3, 4'b1010); ld(3, 255);
    for (int k = 0; k < 3; k++) pulse_ext(1);
    idle(6);
    check("R7 pin 1 source", tcnt(3), 252);
    wr(3, 4'b1011);
    held = tcnt(3); idle(60);
    check("R7 code 11 no counts", tcnt(3), held);
    wr(3, 4'b1001); idle(80);

    // R8 start synchronization
    cur_req = "R8";
    wr(0, 0);
    wr(1, 4'b1010); ld(1, 0);
    wr(2, 4'b0100); ld(2, 255);
    wr(2, 4'b1100);
    for (int k = 0; k < 4; k++) pulse_ext(0);
    idle(8);
    check("R8 timer3 sync spends first event", tcnt(2), 252);
    wr(2, 4'b0000); ld(2, 255); wr(2, 4'b1000);
    for (int k = 0; k < 4; k++) pulse_ext(0);
    idle(8);
    check("R8 timer3 without sync", tcnt(2), 251);
    wr(0, 4'b1100); ld(0, 2); wr(0, 4'b1111);
    idle(200);

    finish_run();
  end
endmodule